// File: doc/BRIEF.md
# Byte-Register Configuration Target on a Two-Wire Serial Bus

This block is a target on a two-wire serial bus (I2C, 7-bit addressing) that gives a host access to a bank of 31 byte-wide configuration registers. SCL and SDA are brought into the system clock domain through synchronizers. SDA is driven open-drain: the block only ever pulls the line low. A write transfer carries the device address, then a subaddress, then any number of data bytes. The pointer advances by one after each data byte, so a single transfer can fill a run of consecutive registers. A read transfer returns bytes from the current pointer onward. The pointer keeps its value between transfers, so a write of only a subaddress followed by a repeated start and a read address is the usual way to read a chosen register.

Two registers have a control role. Bit 1 of register 0 unlocks writes to every other register. Bit 0 of register 30 is an acquisition request: when a write clears it after it was set, the block emits a single-cycle pulse. Downstream logic reads the whole bank through a parallel port. A start or stop condition seen at any bit position abandons the transfer in progress.

Top module: `i2c_cfg_slave`

## Requirements
- R1: After reset, register i holds 0x00 for i = 0 and 0x30 + i for i = 1..30. Register i appears on cfg_regs bits 8i+7:8i. sda_pull_low and acq_pulse are low.
- R2: In the first byte after a start, bits 7:1 are the device address (default 0x2C) and bit 0 is the direction (1 = read). On a match the block pulls SDA low during the ninth SCL pulse.
- R3: A byte whose address does not match is not acknowledged. Every later byte is neither acknowledged nor stored until the next start.
- R4: A subaddress of 0..30 is acknowledged and loaded into the pointer. A subaddress of 31..255 is not acknowledged and the block goes idle, so the data bytes that follow are neither acknowledged nor stored.
- R5: Each write data byte is acknowledged, stored at the pointer and shown on cfg_regs, and then the pointer increments by one.
- R6: A write data byte that arrives when the pointer has reached 31 is not acknowledged and not stored, and the block goes idle.
- R7: While register 0 bit 1 is 0, writes to registers 1..30 are acknowledged but leave the stored values unchanged. Register 0 is writable at all times.
- R8: A read sends the byte at the pointer MSB first. After each byte the host acknowledges, the pointer increments by one. The pointer keeps its value between transfers.
- R9: Once the pointer reaches 30, every further byte of the read repeats register 30.
- R10: After the host leaves SDA high in the ninth clock of a read byte, the block releases SDA, goes idle and does not drive SDA on the clocks that follow.
- R11: A start or stop at any bit position discards the partial byte. A stop returns the block to idle, and a start begins a new address byte.
- R12: A write that takes register 30 bit 0 from 1 to 0 produces exactly one acq_pulse lasting one clock. Any other write, including one that sets the bit, produces none.
- R13: sda_pull_low changes only while SCL is low, never while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must run well above the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock as sensed at the pin |
| sda_in | input | 1 | Bus data as sensed at the pin |
| sda_pull_low | output | 1 | 1 enables the open-drain pull-down on SDA |
| cfg_regs | output | NUM_REGS*8 (248) | All register contents; register i at bits 8i+7:8i |
| acq_pulse | output | 1 | One-clock acquisition request |

## Verification
The bench fills the whole bank in one burst and one byte past the top. It reads from every start index, and far enough to go past register 30, to show that the read saturates there instead of wrapping. A design that wraps would return register 0 at that point, and one that mishandles the top would acknowledge or store the extra byte. Subaddresses from 31 upward and a foreign device address are sent with data behind them, to catch a design that is not refused and still writes. Stops and repeated starts are placed in the middle of bytes, where a design that does not abandon the transfer would store a partial byte or miss the new address. The write lock and the acquisition pulse are tested in both directions, which shows a missing lock, a pulse on the rising write and a pulse wider than one clock.

// File: rtl/i2c_cfg_pkg.sv
// Shared definitions for the serial configuration target.
// Assumes: bank size fixed at 31 bytes for the default image.
package i2c_cfg_pkg;

    localparam int CFG_REGS = 31;

    // Transfer phase of the protocol engine
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEV,
        PH_SUB,
        PH_WR,
        PH_RD
    } phase_t;

    // Default reset image: byte 0 clear, byte i = 0x30 + i otherwise
    function automatic logic [CFG_REGS*8-1:0] default_image();
        logic [CFG_REGS*8-1:0] img;
        img = '0;
        for (int i = 1; i < CFG_REGS; i++) begin
            img[i*8 +: 8] = 8'(8'h30 + i);
        end
        return img;
    endfunction

endpackage

// File: rtl/i2c_cfg_sync.sv
// Brings SCL and SDA into the clk domain and flags bus events.
// Assumes: clk is several times faster than SCL; STAGES >= 2.
// Outputs are single-cycle event strobes plus the settled line levels.
module i2c_cfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_q,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    // Synchronizer chains and one-cycle history, idle-high at reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_q = scl_pipe[STAGES-1];
    assign sda_q = sda_pipe[STAGES-1];

    // Event decode: edges of SCL, SDA edges while SCL stays high
    always_comb begin
        scl_rise  = scl_q & ~scl_d;
        scl_fall  = ~scl_q & scl_d;
        start_det = scl_q & scl_d & sda_d & ~sda_q;
        stop_det  = scl_q & scl_d & ~sda_d & sda_q;
    end

endmodule

// File: rtl/i2c_cfg_regbank.sv
// Register bank with write lock and acquisition-request edge detect.
// Assumes: one write strobe per clock at most; register 0 holds the
// unlock bit and is itself never locked.
module i2c_cfg_regbank #(
    parameter int                      NUM_REGS    = 31,
    parameter int                      AW          = 5,
    parameter int                      WEN_BIT     = 1,
    parameter int                      ACQ_REG     = 30,
    parameter int                      ACQ_BIT     = 0,
    parameter logic [NUM_REGS*8-1:0]   RESET_IMAGE = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_addr,
    input  logic [7:0]            wr_data,
    output logic [NUM_REGS*8-1:0] regs_flat,
    output logic                  acq_pulse
);

    logic unlocked;
    logic acq_prev;

    assign unlocked = regs_flat[WEN_BIT];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [7:0] q;
        logic       allow;
        if (g == 0) begin : g_free
            assign allow = 1'b1;
        end else begin : g_locked
            assign allow = unlocked;
        end
        // Storage for one register, written when addressed and allowed
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= RESET_IMAGE[g*8 +: 8];
            end else if (wr_en && (wr_addr == AW'(g)) && allow) begin
                q <= wr_data;
            end
        end
        assign regs_flat[g*8 +: 8] = q;
    end

    // Previous value of the request bit, for falling-edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acq_prev <= RESET_IMAGE[ACQ_REG*8 + ACQ_BIT];
        end else begin
            acq_prev <= regs_flat[ACQ_REG*8 + ACQ_BIT];
        end
    end

    assign acq_pulse = acq_prev & ~regs_flat[ACQ_REG*8 + ACQ_BIT];

endmodule

// File: rtl/i2c_cfg_fsm.sv
// Bit and byte engine: address match, subaddress, write and read phases.
// Assumes: events come from i2c_cfg_sync; a rise and a fall never share
// a cycle. bit_q counts SCL rises inside a byte: 0..7 data, 8 is the
// acknowledge low phase, 9 the acknowledge high phase.
module i2c_cfg_fsm
    import i2c_cfg_pkg::*;
#(
    parameter int         NUM_REGS = 31,
    parameter int         AW       = 5,
    parameter logic [6:0] DEV_ADDR = 7'h2C
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_rise,
    input  logic                  scl_fall,
    input  logic                  start_det,
    input  logic                  stop_det,
    input  logic                  sda_q,
    input  logic [NUM_REGS*8-1:0] regs_flat,
    output logic                  wr_en,
    output logic [AW-1:0]         wr_addr,
    output logic [7:0]            wr_data,
    output logic                  sda_pull,
    output logic                  idle
);

    localparam logic [7:0]    SUB_LIM = 8'(NUM_REGS);
    localparam logic [AW-1:0] PTR_LIM = AW'(NUM_REGS);
    localparam logic [AW-1:0] PTR_TOP = AW'(NUM_REGS - 1);

    phase_t        phase_q;
    logic [3:0]    bit_q;
    logic [7:0]    shreg_q;
    logic [AW-1:0] ptr_q;
    logic          ack_q;
    logic          rd_drv_q;
    logic          rnw_q;
    logic          mnack_q;

    logic          byte_done;
    logic          ack_end;
    logic [AW-1:0] ptr_nxt;
    logic [AW-1:0] sel_cur;
    logic [AW-1:0] sel_nxt;
    logic [7:0]    cur_byte;
    logic [7:0]    nxt_byte;

    // Phase points and saturating read pointer
    always_comb begin
        byte_done = scl_fall && (bit_q == 4'd8);
        ack_end   = scl_fall && (bit_q == 4'd9);
        ptr_nxt   = (ptr_q >= PTR_TOP) ? ptr_q : ptr_q + 1'b1;
        sel_cur   = (ptr_q > PTR_TOP) ? PTR_TOP : ptr_q;
        sel_nxt   = (ptr_nxt > PTR_TOP) ? PTR_TOP : ptr_nxt;
        cur_byte  = regs_flat[int'(sel_cur)*8 +: 8];
        nxt_byte  = regs_flat[int'(sel_nxt)*8 +: 8];
    end

    // Write strobe toward the bank at the end of each accepted data byte
    always_comb begin
        wr_en   = byte_done && (phase_q == PH_WR) && (ptr_q < PTR_LIM);
        wr_addr = ptr_q;
        wr_data = shreg_q;
    end

    // Protocol sequencing; start and stop override everything else
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            bit_q    <= '0;
            shreg_q  <= '0;
            ptr_q    <= '0;
            ack_q    <= 1'b0;
            rd_drv_q <= 1'b0;
            rnw_q    <= 1'b0;
            mnack_q  <= 1'b0;
        end else if (start_det) begin
            phase_q  <= PH_DEV;
            bit_q    <= '0;
            ack_q    <= 1'b0;
            rd_drv_q <= 1'b0;
        end else if (stop_det) begin
            phase_q  <= PH_IDLE;
            bit_q    <= '0;
            ack_q    <= 1'b0;
            rd_drv_q <= 1'b0;
        end else if (phase_q != PH_IDLE) begin
            if (scl_rise) begin
                if (bit_q < 4'd8) begin
                    shreg_q <= {shreg_q[6:0], sda_q};
                end else if (bit_q == 4'd8) begin
                    mnack_q <= sda_q;
                end
                if (bit_q != 4'd9) begin
                    bit_q <= bit_q + 4'd1;
                end
            end
            if (byte_done) begin
                unique case (phase_q)
                    PH_DEV: begin
                        ack_q <= (shreg_q[7:1] == DEV_ADDR);
                        rnw_q <= shreg_q[0];
                    end
                    PH_SUB: begin
                        if (shreg_q < SUB_LIM) begin
                            ack_q <= 1'b1;
                            ptr_q <= shreg_q[AW-1:0];
                        end
                    end
                    PH_WR: begin
                        if (ptr_q < PTR_LIM) begin
                            ack_q <= 1'b1;
                            ptr_q <= ptr_q + 1'b1;
                        end
                    end
                    PH_RD: rd_drv_q <= 1'b0;
                    default: ;
                endcase
            end else if (ack_end) begin
                bit_q <= '0;
                ack_q <= 1'b0;
                unique case (phase_q)
                    PH_DEV: begin
                        if (!ack_q) begin
                            phase_q <= PH_IDLE;
                        end else if (rnw_q) begin
                            phase_q  <= PH_RD;
                            rd_drv_q <= ~cur_byte[7];
                        end else begin
                            phase_q <= PH_SUB;
                        end
                    end
                    PH_SUB:  phase_q <= ack_q ? PH_WR : PH_IDLE;
                    PH_WR:   if (!ack_q) phase_q <= PH_IDLE;
                    PH_RD: begin
                        if (mnack_q) begin
                            phase_q  <= PH_IDLE;
                            rd_drv_q <= 1'b0;
                        end else begin
                            ptr_q    <= ptr_nxt;
                            rd_drv_q <= ~nxt_byte[7];
                        end
                    end
                    default: ;
                endcase
            end else if (scl_fall && (phase_q == PH_RD) && (bit_q != 4'd0)) begin
                rd_drv_q <= ~cur_byte[3'(4'd7 - bit_q)];
            end
        end
    end

    assign sda_pull = ack_q | rd_drv_q;
    assign idle     = (phase_q == PH_IDLE);

endmodule

// File: rtl/i2c_cfg_slave.sv
// Top of the serial configuration target: synchronizer, protocol engine
// and register bank. Assumes clk runs at least 8x the SCL rate and the
// pad logic turns sda_pull_low into an open-drain pull-down.
module i2c_cfg_slave
    import i2c_cfg_pkg::*;
#(
    parameter logic [6:0]            DEV_ADDR    = 7'h2C,
    parameter int                    NUM_REGS    = CFG_REGS,
    parameter int                    WEN_BIT     = 1,
    parameter int                    ACQ_REG     = 30,
    parameter int                    ACQ_BIT     = 0,
    parameter int                    SYNC_STAGES = 2,
    parameter logic [NUM_REGS*8-1:0] RESET_IMAGE = default_image()
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_in,
    input  logic                  sda_in,
    output logic                  sda_pull_low,
    output logic [NUM_REGS*8-1:0] cfg_regs,
    output logic                  acq_pulse
);

    localparam int AW = $clog2(NUM_REGS + 1);

    logic          scl_s;
    logic          sda_s;
    logic          scl_rise;
    logic          scl_fall;
    logic          start_det;
    logic          stop_det;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic          fsm_idle;

    i2c_cfg_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_q     (scl_s),
        .sda_q     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_cfg_fsm #(
        .NUM_REGS (NUM_REGS),
        .AW       (AW),
        .DEV_ADDR (DEV_ADDR)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_q     (sda_s),
        .regs_flat (cfg_regs),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sda_pull  (sda_pull_low),
        .idle      (fsm_idle)
    );

    i2c_cfg_regbank #(
        .NUM_REGS    (NUM_REGS),
        .AW          (AW),
        .WEN_BIT     (WEN_BIT),
        .ACQ_REG     (ACQ_REG),
        .ACQ_BIT     (ACQ_BIT),
        .RESET_IMAGE (RESET_IMAGE)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .regs_flat (cfg_regs),
        .acq_pulse (acq_pulse)
    );

endmodule

// File: rtl/i2c_cfg_slave_chk.sv
// Temporal checks on the serial configuration target, bound to its top.
// Assumes: signals are observed in the clk domain after synchronization.
module i2c_cfg_slave_chk #(
    parameter int NUM_REGS = 31,
    parameter int WEN_BIT  = 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_s,
    input logic                  start_det,
    input logic                  stop_det,
    input logic                  sda_pull,
    input logic                  idle,
    input logic                  acq_pulse,
    input logic [NUM_REGS*8-1:0] regs_flat
);

    // R13: the pull-down holds steady across a high SCL phase
    assert_drive_steady_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det))
            |-> $stable(sda_pull));

    // R10: an idle engine never pulls SDA
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !sda_pull);

    // R11: a stop leaves the engine idle with SDA released
    assert_stop_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (idle && !sda_pull));

    // R12: the acquisition request lasts one clock
    assert_acq_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        acq_pulse |=> !acq_pulse);

    // R7: while locked, registers above 0 do not change
    assert_locked_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !regs_flat[WEN_BIT] |=> $stable(regs_flat[NUM_REGS*8-1:8]));

endmodule

bind i2c_cfg_slave i2c_cfg_slave_chk #(
    .NUM_REGS (NUM_REGS),
    .WEN_BIT  (WEN_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_pull  (sda_pull_low),
    .idle      (fsm_idle),
    .acq_pulse (acq_pulse),
    .regs_flat (cfg_regs)
);

// File: tb/i2c_cfg_slave_tb.sv
// Bench: bus host model with an arithmetic register model.
module i2c_cfg_slave_tb;

    localparam int         NREG = 31;
    localparam logic [6:0] DEV  = 7'h2C;
    localparam int         Q    = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              scl_m = 1'b1;
    logic              sda_lo = 1'b0;
    logic              sda_pull_low;
    logic [NREG*8-1:0] cfg_regs;
    logic              acq_pulse;
    logic              sda_bus;

    assign sda_bus = ~(sda_lo | sda_pull_low);

    i2c_cfg_slave u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_in       (scl_m),
        .sda_in       (sda_bus),
        .sda_pull_low (sda_pull_low),
        .cfg_regs     (cfg_regs),
        .acq_pulse    (acq_pulse)
    );

    always #2 clk = ~clk;

    int         n_cmp = 0;
    int         n_bad = 0;
    logic [7:0] model [NREG];
    logic [7:0] txbuf [40];
    int         mptr = 0;
    int         exp_pulses = 0;
    int         seen_pulses = 0;
    int         wide_pulses = 0;
    int         drive_viol = 0;
    logic       prev_scl = 1'b1;
    logic       prev_pull = 1'b0;
    logic       prev_acq = 1'b0;
    logic       done = 1'b0;

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic mwrite(input int a, input logic [7:0] d);
        if (a < NREG && (a == 0 || model[0][1])) begin
            if (a == 30 && model[30][0] && !d[0]) exp_pulses++;
            model[a] = d;
        end
    endtask

    task automatic cmp_all(input string req);
        for (int i = 0; i < NREG; i++) begin
            chk(req, 32'(cfg_regs[i*8 +: 8]), 32'(model[i]), $sformatf("register %0d", i));
        end
    endtask

    task automatic qw();
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_lo = 1'b0; qw();
        scl_m  = 1'b1; qw();
        sda_lo = 1'b1; qw();
        scl_m  = 1'b0; qw();
    endtask

    task automatic bus_stop();
        sda_lo = 1'b1; qw();
        scl_m  = 1'b1; qw();
        sda_lo = 1'b0; qw();
    endtask

    task automatic bit_io(input logic b, output logic s);
        sda_lo = ~b;  qw();
        scl_m  = 1'b1; qw();
        s = sda_bus;  qw();
        scl_m  = 1'b0; qw();
    endtask

    task automatic put_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bit_io(b[i], s);
        bit_io(1'b1, s);
        acked = ~s;
    endtask

    task automatic get_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_io(1'b1, s);
            b[i] = s;
        end
        bit_io(~give_ack, s);
    endtask

    // Write transfer: subaddress then n bytes from txbuf
    task automatic write_seq(input logic [7:0] sub, input int n);
        logic a;
        logic alive;
        logic expa;
        bus_start();
        put_byte({DEV, 1'b0}, a);
        chk("R2", 32'(a), 1, "write address ack");
        put_byte(sub, a);
        alive = (sub < 8'(NREG));
        chk("R4", 32'(a), 32'(alive), $sformatf("subaddress %0d ack", sub));
        if (alive) mptr = int'(sub);
        for (int k = 0; k < n; k++) begin
            put_byte(txbuf[k], a);
            expa = alive && (mptr < NREG);
            chk(!alive ? "R4" : (mptr >= NREG ? "R6" : "R5"), 32'(a), 32'(expa),
                $sformatf("data byte %0d ack", k));
            if (expa) begin
                mwrite(mptr, txbuf[k]);
                mptr++;
            end else begin
                alive = 1'b0;
            end
        end
        bus_stop();
    endtask

    // Read transfer of n bytes, optionally setting the pointer first
    task automatic read_seq(input logic set_sub, input logic [7:0] sub, input int n);
        logic       a;
        logic       s;
        logic [7:0] b;
        int         idx;
        if (set_sub) begin
            bus_start();
            put_byte({DEV, 1'b0}, a);
            chk("R2", 32'(a), 1, "address ack before read");
            put_byte(sub, a);
            chk("R4", 32'(a), 1, "read subaddress ack");
            mptr = int'(sub);
        end
        bus_start();
        put_byte({DEV, 1'b1}, a);
        chk("R2", 32'(a), 1, "read address ack");
        for (int k = 0; k < n; k++) begin
            get_byte(k != n - 1, b);
            idx = (mptr > 30) ? 30 : mptr;
            chk((mptr >= 30 && k > 0) ? "R9" : "R8", 32'(b), 32'(model[idx]),
                $sformatf("read byte %0d pointer %0d", k, mptr));
            if (k != n - 1 && mptr < 30) mptr++;
        end
        chk("R10", 32'(sda_pull_low), 0, "released after host nack");
        bit_io(1'b1, s);
        chk("R10", 32'(s), 1, "no drive after host nack");
        bus_stop();
    endtask

    // Bus monitor: pulse width, pulse count, drive changes under high SCL
    always @(negedge clk) begin
        if (rst_n) begin
            if (acq_pulse) seen_pulses++;
            if (acq_pulse && prev_acq) wide_pulses++;
            if (scl_m && prev_scl && (sda_pull_low != prev_pull)) drive_viol++;
        end
        prev_scl  <= scl_m;
        prev_pull <= sda_pull_low;
        prev_acq  <= acq_pulse;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired (all requirements)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic a;
        logic s;
        for (int i = 0; i < NREG; i++) model[i] = (i == 0) ? 8'h00 : 8'(8'h30 + i);
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        qw();

        // R1: reset image and idle outputs
        cmp_all("R1");
        chk("R1", 32'(sda_pull_low), 0, "sda released after reset");
        chk("R1", 32'(acq_pulse), 0, "acq low after reset");

        // R7: locked write to register 5 is acked but dropped
        txbuf[0] = 8'hAA; txbuf[1] = 8'h55;
        write_seq(8'd5, 2);
        chk("R7", 32'(cfg_regs[5*8 +: 8]), 32'(model[5]), "locked register 5");
        chk("R7", 32'(cfg_regs[6*8 +: 8]), 32'(model[6]), "locked register 6");

        // R3: foreign address, then bytes that must be ignored
        bus_start();
        put_byte({7'h2D, 1'b0}, a);
        chk("R3", 32'(a), 0, "foreign address nack");
        put_byte(8'h00, a);
        chk("R3", 32'(a), 0, "byte after foreign address");
        put_byte(8'h02, a);
        chk("R3", 32'(a), 0, "second byte after foreign address");
        bus_stop();
        cmp_all("R3");

        // R4: out-of-range subaddresses with trailing data
        foreach (txbuf[i]) txbuf[i] = 8'h02;
        for (int v = 0; v < 6; v++) begin
            write_seq((v == 0) ? 8'd31 : (v == 1) ? 8'd32 : (v == 2) ? 8'd77 :
                      (v == 3) ? 8'd128 : (v == 4) ? 8'd200 : 8'd255, 1);
        end
        chk("R4", 32'(cfg_regs[7:0]), 32'(model[0]), "register 0 after refused subaddress");

        // R7: register 0 writable while locked; unlock
        txbuf[0] = 8'h02;
        write_seq(8'd0, 1);
        chk("R7", 32'(cfg_regs[7:0]), 32'h02, "register 0 unlocked");

        // R5, R6: burst over registers 1..30 and one past the top
        for (int i = 0; i < 31; i++) txbuf[i] = 8'((i * 29 + 7) ^ 8'hC3);
        write_seq(8'd1, 31);
        cmp_all("R5");

        // R8, R9: read everything and beyond the top
        read_seq(1'b1, 8'd0, 34);

        // R8, R9: four bytes from every starting index
        for (int st = 0; st < NREG; st++) read_seq(1'b1, 8'(st), 4);

        // R8: pointer kept across transfers
        txbuf[0] = 8'h11; txbuf[1] = 8'h22;
        write_seq(8'd10, 2);
        read_seq(1'b0, 8'd0, 3);

        // R11: stop in the middle of a data byte
        bus_start();
        put_byte({DEV, 1'b0}, a);
        put_byte(8'd3, a);
        chk("R4", 32'(a), 1, "subaddress 3 ack");
        for (int i = 0; i < 4; i++) bit_io(1'b1, s);
        bus_stop();
        chk("R11", 32'(cfg_regs[3*8 +: 8]), 32'(model[3]), "register 3 after mid-byte stop");
        chk("R11", 32'(sda_pull_low), 0, "released after mid-byte stop");

        // R11: repeated start in the middle of a data byte
        bus_start();
        put_byte({DEV, 1'b0}, a);
        put_byte(8'd4, a);
        for (int i = 0; i < 5; i++) bit_io(1'b0, s);
        bus_start();
        put_byte({DEV, 1'b0}, a);
        chk("R11", 32'(a), 1, "address after mid-byte start");
        put_byte(8'd6, a);
        put_byte(8'h5C, a);
        chk("R11", 32'(a), 1, "data after mid-byte start");
        mwrite(6, 8'h5C);
        mptr = 7;
        bus_stop();
        chk("R11", 32'(cfg_regs[4*8 +: 8]), 32'(model[4]), "register 4 untouched");
        chk("R11", 32'(cfg_regs[6*8 +: 8]), 32'h5C, "register 6 written");

        // R12: set request bit (no pulse), then clear (one pulse)
        txbuf[0] = 8'h01;
        write_seq(8'd30, 1);
        chk("R12", 32'(seen_pulses), 32'(exp_pulses), "pulses after setting bit");
        txbuf[0] = 8'h00;
        write_seq(8'd30, 1);
        chk("R12", 32'(seen_pulses), 32'(exp_pulses), "pulses after clearing bit");
        chk("R12", 32'(exp_pulses), 1, "model pulse count");
        chk("R12", 32'(wide_pulses), 0, "pulse width one clock");

        // R7: lock again, then attempt a burst
        txbuf[0] = 8'h00;
        write_seq(8'd0, 1);
        for (int i = 0; i < 5; i++) txbuf[i] = 8'(8'hE0 + i);
        write_seq(8'd7, 5);
        cmp_all("R7");

        // R13: no drive change seen while SCL was high
        chk("R13", 32'(drive_viol), 0, "drive changes under high SCL");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule